// File: doc/BRIEF.md
# PLL Power and Retune Sequencer

This block drives the digital control lines of a phase-locked loop macro through three ordered procedures: bringing it up, shutting it down, and changing its frequency. Software or a higher-level controller raises one of three single-cycle requests. The sequencer then walks the control lines through a fixed order, one step per clock, and holds between steps where the macro needs time to settle. The settle waits are expressed in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

The frequency setting has two parts: a feedback code and a power-of-two post-divider exponent. A retune writes both fields in the same cycle, together with a one-cycle change strobe. While this happens the tuner is turned off around the update. A build option drops the active-low reset release, for macros that have no such pin. While a procedure runs, the block reports busy, and it raises a one-cycle done when it returns to idle. Lock detection is not part of the block.

Top module: `pllseq_top`

## Requirements
- R1: After reset, the outputs settle as follows: power off, isolation asserted, PLL enable low, all divider enables low, tuner low, reset (active low) asserted, code and exponent zero, change strobe low, busy low and done low.
- R2: Power-up raises power first. It clears isolation no earlier than SHORT_US*CYC_PER_US cycles after that. It raises PLL enable no earlier than SHORT_US*CYC_PER_US cycles after isolation clears.
- R3: After PLL enable, power-up sets the divider enables selected by DIV_MASK in a later cycle. It then sets the tuner enable in a still later cycle.
- R4: With HAS_RST=1, the reset line goes high no earlier than LONG_US*CYC_PER_US cycles after the tuner enable rises. With HAS_RST=0 the reset line stays low, and done still comes no earlier than that wait.
- R5: Power-down lowers the reset line, the tuner, the divider enables and PLL enable. It then raises isolation and removes power. Each step comes exactly one cycle after the previous one.
- R6: A retune lowers the tuner before the fields change. The code and the exponent take their new values in the same cycle. The change strobe is high for exactly that one cycle, and the tuner is low during it.
- R7: After the field update, a retune puts the tuner back to the state of PLL enable. Done comes no earlier than LONG_US*CYC_PER_US cycles after that.
- R8: The enabled output always equals the PLL enable line.
- R9: Busy is high from the cycle after a request is accepted until done. Done is a single-cycle pulse in the first idle cycle. Requests that arrive while busy have no effect.
- R10: When several requests arrive together in an idle cycle, power-up wins over power-down, and power-down wins over retune.
- R11: Isolation is asserted whenever power is off. PLL enable is high only while power is on and isolation is clear.
- R12: The code and exponent outputs change only in a cycle where the change strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqUp | input | 1 | Power-up request (one cycle) |
| reqDown | input | 1 | Power-down request (one cycle) |
| reqRetune | input | 1 | Retune request (one cycle), samples newCode/newExp |
| newCode | input | CODE_W | Feedback code for a retune |
| newExp | input | EXP_W | Post-divider exponent for a retune |
| busy | output | 1 | A procedure is running |
| done | output | 1 | One-cycle pulse when a procedure finishes |
| enabled | output | 1 | Reported enabled state (the PLL enable line) |
| pwrOn | output | 1 | Macro power switch |
| isoEn | output | 1 | Output isolation |
| pllEn | output | 1 | PLL enable |
| divEn | output | NDIV | Divider-output enables |
| tunerEn | output | 1 | Tuner enable |
| rstBar | output | 1 | Active-low macro reset |
| codeOut | output | CODE_W | Applied feedback code |
| expOut | output | EXP_W | Applied post-divider exponent |
| codeChg | output | 1 | Code-change strobe |

## Verification
There are two cases where two functions can fall in the same clock cycle.

The first is a new request landing in the done cycle of the previous procedure. The bench waits for done and drives a retune request in that very cycle. It judges acceptance by busy rising one cycle later and by the new code appearing on the outputs.

The second is simultaneous requests. The bench raises power-down and retune together while the PLL is up, and power-up and power-down together while it is off. It judges the priority from the control lines and from a code that must stay unchanged. A request raised in the middle of a busy retune must leave the PLL enabled with a single change strobe.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  // Single-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic pwrSet;
    logic pwrClr;
    logic isoSet;
    logic isoClr;
    logic enSet;
    logic enClr;
    logic divSet;
    logic divClr;
    logic tunSet;
    logic tunClr;
    logic tunRestore;
    logic rstSet;
    logic rstClr;
    logic fieldWr;
    logic reqLatch;
    logic waitShort;
    logic waitLong;
  } seqStb_t;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_UP_PWR,
    ST_UP_W1,
    ST_UP_ISO,
    ST_UP_W2,
    ST_UP_EN,
    ST_UP_DIV,
    ST_UP_TUN,
    ST_UP_W3,
    ST_UP_RST,
    ST_DN_RST,
    ST_DN_TUN,
    ST_DN_DIV,
    ST_DN_EN,
    ST_DN_ISO,
    ST_DN_PWR,
    ST_RT_TOFF,
    ST_RT_WR,
    ST_RT_TON,
    ST_RT_W
  } seqSt_t;

endpackage

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter bit HAS_RST = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqUp,
  input  logic    reqDown,
  input  logic    reqRetune,
  input  logic    waitDone,
  output seqStb_t stb,
  output logic    busy,
  output logic    done
);

  seqSt_t stQ, stNxt;

  always_comb begin
    stNxt = stQ;
    stb   = '0;
    unique case (stQ)
      ST_IDLE: begin
        // fixed priority: up, then down, then retune
        if (reqUp) begin
          stNxt = ST_UP_PWR;
        end else if (reqDown) begin
          stNxt = ST_DN_RST;
        end else if (reqRetune) begin
          stNxt        = ST_RT_TOFF;
          stb.reqLatch = 1'b1;
        end
      end
      ST_UP_PWR: begin
        stb.pwrSet    = 1'b1;
        stb.waitShort = 1'b1;
        stNxt         = ST_UP_W1;
      end
      ST_UP_W1:  if (waitDone) stNxt = ST_UP_ISO;
      ST_UP_ISO: begin
        stb.isoClr    = 1'b1;
        stb.waitShort = 1'b1;
        stNxt         = ST_UP_W2;
      end
      ST_UP_W2:  if (waitDone) stNxt = ST_UP_EN;
      ST_UP_EN: begin
        stb.enSet = 1'b1;
        stNxt     = ST_UP_DIV;
      end
      ST_UP_DIV: begin
        stb.divSet = 1'b1;
        stNxt      = ST_UP_TUN;
      end
      ST_UP_TUN: begin
        stb.tunSet   = 1'b1;
        stb.waitLong = 1'b1;
        stNxt        = ST_UP_W3;
      end
      ST_UP_W3: begin
        if (waitDone) stNxt = HAS_RST ? ST_UP_RST : ST_IDLE;
      end
      ST_UP_RST: begin
        stb.rstSet = 1'b1;
        stNxt      = ST_IDLE;
      end
      ST_DN_RST: begin
        stb.rstClr = 1'b1;
        stNxt      = ST_DN_TUN;
      end
      ST_DN_TUN: begin
        stb.tunClr = 1'b1;
        stNxt      = ST_DN_DIV;
      end
      ST_DN_DIV: begin
        stb.divClr = 1'b1;
        stNxt      = ST_DN_EN;
      end
      ST_DN_EN: begin
        stb.enClr = 1'b1;
        stNxt     = ST_DN_ISO;
      end
      ST_DN_ISO: begin
        stb.isoSet = 1'b1;
        stNxt      = ST_DN_PWR;
      end
      ST_DN_PWR: begin
        stb.pwrClr = 1'b1;
        stNxt      = ST_IDLE;
      end
      ST_RT_TOFF: begin
        stb.tunClr = 1'b1;
        stNxt      = ST_RT_WR;
      end
      ST_RT_WR: begin
        stb.fieldWr = 1'b1;
        stNxt       = ST_RT_TON;
      end
      ST_RT_TON: begin
        stb.tunRestore = 1'b1;
        stb.waitLong   = 1'b1;
        stNxt          = ST_RT_W;
      end
      ST_RT_W:   if (waitDone) stNxt = ST_IDLE;
      default:   stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ  <= ST_IDLE;
      done <= 1'b0;
    end else begin
      stQ  <= stNxt;
      done <= (stQ != ST_IDLE) && (stNxt == ST_IDLE);
    end
  end

  assign busy = (stQ != ST_IDLE);

  // R9: done lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: busy only drops together with a done pulse
  p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2: a wait is only started once the previous one has run out
  p_wait_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.waitShort || stb.waitLong) |-> waitDone);

endmodule

// File: rtl/pllseq_dp.sv
module pllseq_dp
  import pllseq_pkg::*;
#(
  parameter int             CYC_PER_US = 50,
  parameter int             SHORT_US   = 1,
  parameter int             LONG_US    = 20,
  parameter int             CODE_W     = 22,
  parameter int             EXP_W      = 3,
  parameter int             NDIV       = 2,
  parameter logic [NDIV-1:0] DIV_MASK  = '1,
  parameter bit             HAS_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStb_t           stb,
  input  logic [CODE_W-1:0] newCode,
  input  logic [EXP_W-1:0]  newExp,
  output logic              waitDone,
  output logic              pwrOn,
  output logic              isoEn,
  output logic              pllEn,
  output logic [NDIV-1:0]   divEn,
  output logic              tunerEn,
  output logic              rstBar,
  output logic [CODE_W-1:0] codeOut,
  output logic [EXP_W-1:0]  expOut,
  output logic              codeChg
);

  localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int CNT_W     = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0]  cntQ;
  logic [CODE_W-1:0] pendCode;
  logic [EXP_W-1:0]  pendExp;

  // settle timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (stb.waitLong) begin
      cntQ <= CNT_W'(LONG_CYC);
    end else if (stb.waitShort) begin
      cntQ <= CNT_W'(SHORT_CYC);
    end else if (cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign waitDone = (cntQ == '0);

  // power, isolation, enable, tuner
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrOn   <= 1'b0;
      isoEn   <= 1'b1;
      pllEn   <= 1'b0;
      tunerEn <= 1'b0;
    end else begin
      if (stb.pwrSet) pwrOn <= 1'b1;
      else if (stb.pwrClr) pwrOn <= 1'b0;
      if (stb.isoSet) isoEn <= 1'b1;
      else if (stb.isoClr) isoEn <= 1'b0;
      if (stb.enSet) pllEn <= 1'b1;
      else if (stb.enClr) pllEn <= 1'b0;
      if (stb.tunSet) tunerEn <= 1'b1;
      else if (stb.tunRestore) tunerEn <= pllEn;
      else if (stb.tunClr) tunerEn <= 1'b0;
    end
  end

  // divider-output enables, only those selected by the mask exist
  for (genvar i = 0; i < NDIV; i++) begin : g_div
    if (DIV_MASK[i]) begin : g_on
      logic bitQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bitQ <= 1'b0;
        else if (stb.divSet) bitQ <= 1'b1;
        else if (stb.divClr) bitQ <= 1'b0;
      end
      assign divEn[i] = bitQ;
    end else begin : g_off
      assign divEn[i] = 1'b0;
    end
  end

  // optional active-low reset release
  if (HAS_RST) begin : g_rst
    logic rstQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rstQ <= 1'b0;
      else if (stb.rstSet) rstQ <= 1'b1;
      else if (stb.rstClr) rstQ <= 1'b0;
    end
    assign rstBar = rstQ;

    // R5: the reset is released only while the PLL is enabled
    p_rst_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rstBar |-> pllEn);
  end else begin : g_norst
    assign rstBar = 1'b0;
  end

  // retune fields: captured at request, applied together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCode <= '0;
      pendExp  <= '0;
      codeOut  <= '0;
      expOut   <= '0;
      codeChg  <= 1'b0;
    end else begin
      if (stb.reqLatch) begin
        pendCode <= newCode;
        pendExp  <= newExp;
      end
      if (stb.fieldWr) begin
        codeOut <= pendCode;
        expOut  <= pendExp;
      end
      codeChg <= stb.fieldWr;
    end
  end

  // R11: isolation held whenever power is off
  p_iso_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrOn |-> isoEn);

  // R11: enable only on a powered, unisolated macro
  p_en_needs_power_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pllEn |-> (pwrOn && !isoEn));

  // R3: tuner runs only with the PLL enabled
  p_tuner_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tunerEn |-> pllEn);

  // R12: fields move only with the strobe
  p_field_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({codeOut, expOut}) |-> codeChg);

  // R6: tuner is off while the fields change
  p_tuner_off_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    codeChg |-> !tunerEn);

endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int             CYC_PER_US = 50,
  parameter int             SHORT_US   = 1,
  parameter int             LONG_US    = 20,
  parameter int             CODE_W     = 22,
  parameter int             EXP_W      = 3,
  parameter int             NDIV       = 2,
  parameter logic [NDIV-1:0] DIV_MASK  = '1,
  parameter bit             HAS_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqUp,
  input  logic              reqDown,
  input  logic              reqRetune,
  input  logic [CODE_W-1:0] newCode,
  input  logic [EXP_W-1:0]  newExp,
  output logic              busy,
  output logic              done,
  output logic              enabled,
  output logic              pwrOn,
  output logic              isoEn,
  output logic              pllEn,
  output logic [NDIV-1:0]   divEn,
  output logic              tunerEn,
  output logic              rstBar,
  output logic [CODE_W-1:0] codeOut,
  output logic [EXP_W-1:0]  expOut,
  output logic              codeChg
);

  seqStb_t stb;
  logic    waitDone;

  pllseq_ctrl #(.HAS_RST(HAS_RST)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqUp    (reqUp),
    .reqDown  (reqDown),
    .reqRetune(reqRetune),
    .waitDone (waitDone),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  pllseq_dp #(
    .CYC_PER_US(CYC_PER_US),
    .SHORT_US  (SHORT_US),
    .LONG_US   (LONG_US),
    .CODE_W    (CODE_W),
    .EXP_W     (EXP_W),
    .NDIV      (NDIV),
    .DIV_MASK  (DIV_MASK),
    .HAS_RST   (HAS_RST)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .newCode (newCode),
    .newExp  (newExp),
    .waitDone(waitDone),
    .pwrOn   (pwrOn),
    .isoEn   (isoEn),
    .pllEn   (pllEn),
    .divEn   (divEn),
    .tunerEn (tunerEn),
    .rstBar  (rstBar),
    .codeOut (codeOut),
    .expOut  (expOut),
    .codeChg (codeChg)
  );

  assign enabled = pllEn;

endmodule

// File: tb/sim_pllseq_top.sv
`timescale 1ns/1ps
module sim_pllseq_top;

  localparam int CYC  = 4;
  localparam int S    = 1 * CYC;
  localparam int L    = 20 * CYC;
  localparam int CW   = 22;
  localparam int EW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqUp = 1'b0, reqDown = 1'b0, reqRetune = 1'b0;
  logic [CW-1:0] newCode = '0;
  logic [EW-1:0] newExp = '0;
  logic busy, done, enabled, pwrOn, isoEn, pllEn, tunerEn, rstBar, codeChg;
  logic [1:0] divEn;
  logic [CW-1:0] codeOut;
  logic [EW-1:0] expOut;

  // second instance without the reset-release step
  logic u1Up = 1'b0;
  logic u1Busy, u1Done, u1En, u1Pwr, u1Iso, u1Pll, u1Tun, u1Rst, u1Chg;
  logic [1:0] u1Div;
  logic [CW-1:0] u1Code;
  logic [EW-1:0] u1Exp;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pllseq_top #(.CYC_PER_US(CYC), .CODE_W(CW), .EXP_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .reqUp(reqUp), .reqDown(reqDown),
    .reqRetune(reqRetune), .newCode(newCode), .newExp(newExp),
    .busy(busy), .done(done), .enabled(enabled), .pwrOn(pwrOn),
    .isoEn(isoEn), .pllEn(pllEn), .divEn(divEn), .tunerEn(tunerEn),
    .rstBar(rstBar), .codeOut(codeOut), .expOut(expOut), .codeChg(codeChg)
  );

  pllseq_top #(.CYC_PER_US(CYC), .CODE_W(CW), .EXP_W(EW), .HAS_RST(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .reqUp(u1Up), .reqDown(1'b0),
    .reqRetune(1'b0), .newCode('0), .newExp('0),
    .busy(u1Busy), .done(u1Done), .enabled(u1En), .pwrOn(u1Pwr),
    .isoEn(u1Iso), .pllEn(u1Pll), .divEn(u1Div), .tunerEn(u1Tun),
    .rstBar(u1Rst), .codeOut(u1Code), .expOut(u1Exp), .codeChg(u1Chg)
  );

  // event monitor, sampled on the falling edge
  int cyc = 0;
  int tPwrUp, tPwrDn, tIsoUp, tIsoDn, tEnUp, tEnDn, tDivUp, tDivDn;
  int tTunUp, tTunDn, tRstUp, tRstDn, tChg, tCode, tExp, tDone;
  int chgCnt = 0, doneRun = 0, doneMax = 0, enMismatch = 0;
  logic pPwr = 0, pIso = 1, pEn = 0, pTun = 0, pRst = 0;
  logic [1:0] pDiv = 0;
  logic [CW-1:0] pCode = 0;
  logic [EW-1:0] pExp = 0;

  always @(negedge clk) begin
    cyc++;
    if (pwrOn !== pPwr) begin if (pwrOn) tPwrUp = cyc; else tPwrDn = cyc; end
    if (isoEn !== pIso) begin if (isoEn) tIsoUp = cyc; else tIsoDn = cyc; end
    if (pllEn !== pEn) begin if (pllEn) tEnUp = cyc; else tEnDn = cyc; end
    if (divEn !== pDiv) begin if (divEn != 0) tDivUp = cyc; else tDivDn = cyc; end
    if (tunerEn !== pTun) begin if (tunerEn) tTunUp = cyc; else tTunDn = cyc; end
    if (rstBar !== pRst) begin if (rstBar) tRstUp = cyc; else tRstDn = cyc; end
    if (codeOut !== pCode) tCode = cyc;
    if (expOut !== pExp) tExp = cyc;
    if (codeChg) begin tChg = cyc; chgCnt++; end
    if (done) begin doneRun++; tDone = cyc; if (doneRun > doneMax) doneMax = doneRun; end
    else doneRun = 0;
    if (enabled !== pllEn) enMismatch++;
    pPwr = pwrOn; pIso = isoEn; pEn = pllEn; pTun = tunerEn; pRst = rstBar;
    pDiv = divEn; pCode = codeOut; pExp = expOut;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitDoneU0();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, "R9", "done reached", n, 2000);
  endtask

  task automatic t_reset();
    chk(!pwrOn && isoEn && !pllEn && divEn == 0, "R1", "power lines", {pwrOn, isoEn, pllEn}, 3'b010);
    chk(!tunerEn && !rstBar && !codeChg, "R1", "tuner/reset/strobe", {tunerEn, rstBar, codeChg}, 0);
    chk(codeOut == 0 && expOut == 0, "R1", "fields", codeOut, 0);
    chk(!busy && !done && !enabled, "R1", "status", {busy, done, enabled}, 0);
  endtask

  task automatic t_powerUp();
    doneMax = 0;
    @(negedge clk) reqUp = 1;
    @(negedge clk) reqUp = 0;
    chk(busy, "R9", "busy after up request", busy, 1);
    waitDoneU0();
    @(negedge clk);
    chk(tIsoDn - tPwrUp >= S, "R2", "power->iso gap", tIsoDn - tPwrUp, S);
    chk(tEnUp - tIsoDn >= S, "R2", "iso->enable gap", tEnUp - tIsoDn, S);
    chk(tDivUp > tEnUp, "R3", "divider after enable", tDivUp, tEnUp + 1);
    chk(tTunUp > tDivUp, "R3", "tuner after divider", tTunUp, tDivUp + 1);
    chk(divEn == 2'b11, "R3", "divider enables", divEn, 3);
    chk(tRstUp - tTunUp >= L, "R4", "tuner->reset gap", tRstUp - tTunUp, L);
    chk(rstBar && pllEn && tunerEn && pwrOn && !isoEn, "R4", "final up state", rstBar, 1);
    chk(enabled && enMismatch == 0, "R8", "enabled tracks enable", enMismatch, 0);
    chk(doneMax == 1 && !busy, "R9", "done width", doneMax, 1);
  endtask

  task automatic t_retune(input logic [CW-1:0] c, input logic [EW-1:0] e);
    int chg0 = chgCnt;
    newCode = c; newExp = e;
    @(negedge clk) reqRetune = 1;
    @(negedge clk) begin reqRetune = 0; newCode = '0; newExp = '0; end
    repeat (10) @(negedge clk);
    reqDown = 1;             // must be ignored while busy
    @(negedge clk) reqDown = 0;
    waitDoneU0();
    @(negedge clk);
    chk(tTunDn < tChg, "R6", "tuner off before update", tTunDn, tChg - 1);
    chk(tCode == tChg && tExp == tChg, "R6", "atomic field update", tExp, tChg);
    chk(codeOut == c && expOut == e, "R6", "new fields", codeOut, c);
    chk(chgCnt - chg0 == 1, "R6", "one strobe", chgCnt - chg0, 1);
    chk(tTunUp > tChg && tunerEn, "R7", "tuner restored", tTunUp, tChg + 1);
    chk(tDone - tTunUp >= L, "R7", "settle after restore", tDone - tTunUp, L);
    chk(pllEn && pwrOn, "R9", "request while busy ignored", pllEn, 1);
  endtask

  task automatic t_doneCycle();
    newCode = 22'h15A5A; newExp = 3'd5;
    @(negedge clk) reqRetune = 1;
    @(negedge clk) reqRetune = 0;
    waitDoneU0();
    newCode = 22'h0C3C3; newExp = 3'd1;
    reqRetune = 1;           // lands in the done cycle
    @(negedge clk) reqRetune = 0;
    chk(busy, "R9", "request in done cycle accepted", busy, 1);
    waitDoneU0();
    @(negedge clk);
    chk(codeOut == 22'h0C3C3 && expOut == 3'd1, "R9", "second retune fields", codeOut, 22'h0C3C3);
  endtask

  task automatic t_downPriority();
    logic [CW-1:0] keep = codeOut;
    newCode = 22'h3FFFF; newExp = 3'd7;
    @(negedge clk) begin reqDown = 1; reqRetune = 1; end
    @(negedge clk) begin reqDown = 0; reqRetune = 0; end
    waitDoneU0();
    @(negedge clk);
    chk(codeOut == keep, "R10", "down beats retune", codeOut, keep);
    chk(tTunDn == tRstDn + 1 && tDivDn == tRstDn + 2, "R5", "reset/tuner/divider steps", tDivDn - tRstDn, 2);
    chk(tEnDn == tRstDn + 3 && tIsoUp == tRstDn + 4 && tPwrDn == tRstDn + 5, "R5", "enable/iso/power steps", tPwrDn - tRstDn, 5);
    chk(!pwrOn && isoEn && !pllEn && divEn == 0 && !enabled, "R5", "final down state", pwrOn, 0);
  endtask

  task automatic t_upPriority();
    @(negedge clk) begin reqUp = 1; reqDown = 1; end
    @(negedge clk) begin reqUp = 0; reqDown = 0; end
    waitDoneU0();
    @(negedge clk);
    chk(pllEn && rstBar && pwrOn, "R10", "up beats down", pllEn, 1);
  endtask

  task automatic t_noReset();
    int tTun = -1, n = 0, tD = -1;
    @(negedge clk) u1Up = 1;
    @(negedge clk) u1Up = 0;
    while (n < 2000 && tD < 0) begin
      if (u1Tun && tTun < 0) tTun = n;
      if (u1Done) tD = n;
      chk(!u1Rst, "R4", "reset stays low without option", u1Rst, 0);
      @(negedge clk); n++;
    end
    chk(tTun >= 0 && tD - tTun >= L, "R4", "settle without reset step", tD - tTun, L);
    chk(u1Pll && u1Tun && !u1Rst, "R4", "final state without option", u1Rst, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_powerUp();
    t_retune(22'h2ABCD, 3'd2);
    t_doneCycle();
    t_downPriority();
    t_upPriority();
    t_noReset();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule